// File: doc/BRIEF.md
# Calendar alarm comparator

This block holds four alarm settings (minute, hour, day of month and day of week) and compares them with the current time from a separate timekeeping core. The core pulses `tick_min` once each minute, in the cycle where its BCD time fields first show the new minute. On that pulse every field that is armed must equal the current value. If they all do, the block sets a sticky alarm flag. Seconds are not compared, so the alarm has a resolution of one minute.

Software reaches the four alarm bytes and two bits of a shared control byte through a small byte-wide register port. Bit 7 of each alarm byte takes that field out of the comparison. The flag can drive an active-low interrupt pin that is shared with a timer source. The pin stays low until software writes a 0 to the flag bit. The usual software sequence is: clear the interrupt enable, rewrite the alarm bytes, then set the enable again.

Top module: `cal_alarm_cmp`

## Requirements
- R1: While and after reset, the alarm flag and the interrupt enable read 0, `irq_n` is 1, and each of the four alarm bytes reads 0x80 (field off).
- R2: The alarm bytes sit at fixed addresses: minute at 0x9, hour at 0xA, day at 0xB, weekday at 0xC. A write stores bit 7 plus the low 7, 6, 6 and 3 bits respectively, and the other bits read 0. Read data shows on `reg_rdata` one cycle after the address is presented.
- R3: The control byte is at 0x1. Bit 3 is the alarm flag and bit 1 is the interrupt enable, which can be read and written. All other bits read 0.
- R4: On a cycle with `tick_min` high, if every armed field equals its current BCD time field, the flag is set at the next clock edge.
- R5: A field whose bit 7 is 1 takes no part in the comparison. Any current value of that field is accepted.
- R6: If all four fields have bit 7 set, a tick never sets the flag.
- R7: Without `tick_min`, matching time values never set the flag.
- R8: Once set, the flag stays set until a write to 0x1 with bit 3 = 0. Writing bit 3 = 1 neither sets nor clears it.
- R9: If a match and a clearing write happen in the same cycle, the flag ends up set.
- R10: `irq_n` is registered. One cycle after the inputs, it is low exactly when (flag AND enable) is 1 or `tmr_irq_n` is 0.
- R11: The enable bit only gates `irq_n`. A match sets the flag even when the enable is 0.
- R12: Writes to addresses other than 0x1 and 0x9–0xC change nothing, and reads of those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_min | input | 1 | Minute-rollover pulse from the timekeeping core |
| cur_min | input | 7 | Current minute, BCD |
| cur_hour | input | 6 | Current hour, BCD |
| cur_day | input | 6 | Current day of month, BCD |
| cur_wday | input | 3 | Current weekday |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| tmr_irq_n | input | 1 | Active-low timer interrupt sharing the pin |
| irq_n | output | 1 | Shared active-low interrupt |

## Verification
The hardest case to reach from the ports is a partial match: some armed fields agree with the time and exactly one armed field differs, while the disabled fields hold arbitrary values. The bench covers this by sweeping all 16 disable masks against all 16 patterns of which fields differ. It rebuilds the alarm values for every case, so the stored bytes and the current time vary throughout the sweep. The same-cycle clash between a match and a clearing write is forced by driving the tick and the write on the same clock edge.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int NFIELD  = 4;
  localparam int CMP_W   = 7;
  localparam int OFF_BIT = 7;
  localparam logic [7:0] CFG_RESET = 8'h80;

  // bits kept on a write: the off bit plus the field's value bits
  function automatic logic [7:0] keep_mask(input int w);
    logic [8:0] ones;
    ones = (9'd1 << w) - 9'd1;
    return 8'h80 | ones[7:0];
  endfunction
endpackage

// File: rtl/alarm_cfg_regs.sv
module alarm_cfg_regs
  import cal_alarm_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int ALM_BASE = 9,
  parameter int MIN_W    = 7,
  parameter int HOUR_W   = 6,
  parameter int DAY_W    = 6,
  parameter int WDAY_W   = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [7:0]             wdata,
  output logic [NFIELD-1:0][7:0] cfg
);
  localparam int FW [NFIELD] = '{MIN_W, HOUR_W, DAY_W, WDAY_W};

  for (genvar g = 0; g < NFIELD; g++) begin : g_reg
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(ALM_BASE + g);
    localparam logic [7:0]        MASK    = keep_mask(FW[g]);
    always_ff @(posedge clk) begin
      if (rst)
        cfg[g] <= CFG_RESET;
      else if (wr && addr == MY_ADDR)
        cfg[g] <= wdata & MASK;
    end
  end
endmodule

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp
  import cal_alarm_pkg::*;
(
  input  logic [7:0]       cfg,
  input  logic [CMP_W-1:0] cur,
  output logic             ok,
  output logic             armed
);
  // value bits above the field width are zero in both operands
  always_comb begin
    armed = !cfg[OFF_BIT];
    ok    = cfg[OFF_BIT] || (cfg[CMP_W-1:0] == cur);
  end
endmodule

// File: rtl/alarm_flag_ctrl.sv
module alarm_flag_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic all_ok,
  input  logic any_armed,
  input  logic ctrl_wr,
  input  logic wflag,
  input  logic wien,
  input  logic tmr_irq_n,
  output logic flag,
  output logic ien,
  output logic irq_n
);
  logic match_evt;
  assign match_evt = tick && all_ok && any_armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag  <= 1'b0;
      ien   <= 1'b0;
      irq_n <= 1'b1;
    end else begin
      if (match_evt)
        flag <= 1'b1;
      else if (ctrl_wr && !wflag)
        flag <= 1'b0;
      if (ctrl_wr)
        ien <= wien;
      irq_n <= tmr_irq_n & ~(flag & ien);
    end
  end
endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
  import cal_alarm_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int MIN_W      = 7,
  parameter int HOUR_W     = 6,
  parameter int DAY_W      = 6,
  parameter int WDAY_W     = 3,
  parameter int ALM_BASE   = 9,
  parameter int CTRL2_ADDR = 1,
  parameter int FLAG_BIT   = 3,
  parameter int IEN_BIT    = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_min,
  input  logic [MIN_W-1:0]  cur_min,
  input  logic [HOUR_W-1:0] cur_hour,
  input  logic [DAY_W-1:0]  cur_day,
  input  logic [WDAY_W-1:0] cur_wday,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              tmr_irq_n,
  output logic              irq_n
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL2_ADDR);

  logic [NFIELD-1:0][7:0]       alm_cfg;
  logic [NFIELD-1:0][CMP_W-1:0] cur_arr;
  logic [NFIELD-1:0]            fld_ok;
  logic [NFIELD-1:0]            fld_armed;
  logic                         alm_flag;
  logic                         alm_ien;
  logic                         ctrl_wr;
  logic [7:0]                   rd_d;

  assign cur_arr[0] = CMP_W'(cur_min);
  assign cur_arr[1] = CMP_W'(cur_hour);
  assign cur_arr[2] = CMP_W'(cur_day);
  assign cur_arr[3] = CMP_W'(cur_wday);

  assign ctrl_wr = reg_wr && (reg_addr == CTRL_A);

  alarm_cfg_regs #(
    .ADDR_W(ADDR_W), .ALM_BASE(ALM_BASE), .MIN_W(MIN_W),
    .HOUR_W(HOUR_W), .DAY_W(DAY_W), .WDAY_W(WDAY_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .cfg(alm_cfg)
  );

  for (genvar g = 0; g < NFIELD; g++) begin : g_cmp
    alarm_field_cmp u_cmp (
      .cfg(alm_cfg[g]), .cur(cur_arr[g]),
      .ok(fld_ok[g]), .armed(fld_armed[g])
    );
  end

  alarm_flag_ctrl u_flag (
    .clk(clk), .rst(rst), .tick(tick_min),
    .all_ok(&fld_ok), .any_armed(|fld_armed),
    .ctrl_wr(ctrl_wr), .wflag(reg_wdata[FLAG_BIT]), .wien(reg_wdata[IEN_BIT]),
    .tmr_irq_n(tmr_irq_n),
    .flag(alm_flag), .ien(alm_ien), .irq_n(irq_n)
  );

  always_comb begin
    rd_d = '0;
    if (reg_addr == CTRL_A) begin
      rd_d[FLAG_BIT] = alm_flag;
      rd_d[IEN_BIT]  = alm_ien;
    end
    for (int i = 0; i < NFIELD; i++)
      if (reg_addr == ADDR_W'(ALM_BASE + i))
        rd_d = alm_cfg[i];
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_d;
  end
endmodule

// File: rtl/cal_alarm_chk.sv
module cal_alarm_chk #(
  parameter int ADDR_W     = 4,
  parameter int CTRL2_ADDR = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_min,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              wflag,
  input logic              tmr_irq_n,
  input logic              irq_n,
  input logic              flag,
  input logic              ien
);
  logic clr_wr;
  assign clr_wr = reg_wr && (reg_addr == ADDR_W'(CTRL2_ADDR)) && !wflag;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!flag && !ien && irq_n));

  // R4
  flag_rise_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(tick_min));

  // R8
  flag_fall_by_write_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(flag) |-> $past(clr_wr));

  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr_wr) |=> flag);

  // R10
  irq_low_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> $past((flag && ien) || !tmr_irq_n));

  // R10
  irq_high_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_n && !$past(rst)) |-> $past(!(flag && ien) && tmr_irq_n));
endmodule

bind cal_alarm_cmp cal_alarm_chk #(.ADDR_W(ADDR_W), .CTRL2_ADDR(CTRL2_ADDR)) u_chk (
  .clk(clk), .rst(rst), .tick_min(tick_min), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .wflag(reg_wdata[FLAG_BIT]), .tmr_irq_n(tmr_irq_n),
  .irq_n(irq_n), .flag(alm_flag), .ien(alm_ien)
);

// File: tb/sim_cal_alarm_cmp.sv
module sim_cal_alarm_cmp;
  localparam logic [3:0] A_CTL = 4'h1, A_MIN = 4'h9, A_HR = 4'hA, A_DAY = 4'hB, A_WD = 4'hC;

  logic clk = 1'b0, rst = 1'b1, tick_min = 1'b0, reg_wr = 1'b0, tmr_irq_n = 1'b1;
  logic [6:0] cur_min = '0;
  logic [5:0] cur_hour = '0, cur_day = '0;
  logic [2:0] cur_wday = '0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata, rv;
  logic irq_n;
  int checks = 0, errors = 0;

  cal_alarm_cmp u0 (
    .clk(clk), .rst(rst), .tick_min(tick_min), .cur_min(cur_min),
    .cur_hour(cur_hour), .cur_day(cur_day), .cur_wday(cur_wday),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tmr_irq_n(tmr_irq_n), .irq_n(irq_n)
  );

  always #5 clk = ~clk;

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic set_time(input int m, input int h, input int dy, input int w);
    cur_min = 7'(bcd(m)); cur_hour = 6'(bcd(h)); cur_day = 6'(bcd(dy)); cur_wday = 3'(w);
  endtask

  task automatic tick(input int m, input int h, input int dy, input int w);
    @(negedge clk); set_time(m, h, dy, w); tick_min = 1'b1;
    @(negedge clk); tick_min = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
    rst = 1'b0;
    rd(A_CTL, rv); chk("R1 ctrl", rv, 8'h00);
    rd(A_MIN, rv); chk("R1 min", rv, 8'h80);
    rd(A_HR,  rv); chk("R1 hour", rv, 8'h80);
    rd(A_DAY, rv); chk("R1 day", rv, 8'h80);
    rd(A_WD,  rv); chk("R1 wday", rv, 8'h80);
    // R6 all fields off: no alarm after reset even on a tick
    tick(0, 0, 0, 0);
    rd(A_CTL, rv); chk("R6 all off", rv, 8'h00);

    // R2 write masking
    wr(A_MIN, 8'hFF); wr(A_HR, 8'hFF); wr(A_DAY, 8'hFF); wr(A_WD, 8'hFF);
    rd(A_MIN, rv); chk("R2 min mask", rv, 8'hFF);
    rd(A_HR,  rv); chk("R2 hour mask", rv, 8'hBF);
    rd(A_DAY, rv); chk("R2 day mask", rv, 8'hBF);
    rd(A_WD,  rv); chk("R2 wday mask", rv, 8'h87);
    // R3 control byte: only enable settable, flag not set by writing 1
    wr(A_CTL, 8'hFF);
    rd(A_CTL, rv); chk("R3 ctrl bits", rv, 8'h02);
    wr(A_CTL, 8'h00);
    // R12 other addresses ignored
    wr(4'h0, 8'hFF); wr(4'hD, 8'h00); wr(4'h8, 8'h00);
    rd(A_MIN, rv); chk("R12 min kept", rv, 8'hFF);
    rd(A_WD,  rv); chk("R12 wday kept", rv, 8'h87);
    rd(A_CTL, rv); chk("R12 ctrl kept", rv, 8'h00);
    rd(4'hD,  rv); chk("R12 unmapped read", rv, 8'h00);

    // R4 R5 R6 sweep: disable mask x differing-field pattern
    for (int m = 0; m < 16; m++) begin
      for (int p = 0; p < 16; p++) begin
        int k, av[4], cv[4], md[4], base[4];
        logic expf;
        k = m * 16 + p;
        av[0] = k % 60; av[1] = k % 24; av[2] = 1 + k % 31; av[3] = k % 7;
        md[0] = 60; md[1] = 24; md[2] = 31; md[3] = 7;
        base[0] = 0; base[1] = 0; base[2] = 1; base[3] = 0;
        for (int i = 0; i < 4; i++)
          cv[i] = p[i] ? base[i] + ((av[i] - base[i] + 1) % md[i]) : av[i];
        wr(A_CTL, 8'h00);
        wr(A_MIN, bcd(av[0]) | (m[0] ? 8'h80 : 8'h00));
        wr(A_HR,  bcd(av[1]) | (m[1] ? 8'h80 : 8'h00));
        wr(A_DAY, bcd(av[2]) | (m[2] ? 8'h80 : 8'h00));
        wr(A_WD,  bcd(av[3]) | (m[3] ? 8'h80 : 8'h00));
        wr(A_CTL, 8'h02);
        tick(cv[0], cv[1], cv[2], cv[3]);
        expf = (m != 15) && ((p & ~m & 15) == 0);
        rd(A_CTL, rv); chk($sformatf("R4 R5 R6 m=%0d p=%0d flag", m, p), rv, {4'd0, expf, 3'b010});
        chk($sformatf("R10 m=%0d p=%0d irq", m, p), {7'd0, irq_n}, {7'd0, !expf});
      end
    end

    // R7 equal time without tick
    wr(A_CTL, 8'h02);
    wr(A_MIN, bcd(30)); wr(A_HR, bcd(12)); wr(A_DAY, bcd(15)); wr(A_WD, 8'h03);
    @(negedge clk); set_time(30, 12, 15, 3);
    repeat (5) @(negedge clk);
    rd(A_CTL, rv); chk("R7 no tick", rv, 8'h02);
    chk("R7 irq", {7'd0, irq_n}, 8'h01);

    // R11 enable off: flag sets, irq stays high
    wr(A_CTL, 8'h00);
    tick(30, 12, 15, 3);
    rd(A_CTL, rv); chk("R11 flag", rv, 8'h08);
    chk("R11 irq high", {7'd0, irq_n}, 8'h01);
    // R10 enabling raises irq
    wr(A_CTL, 8'h0A);
    @(negedge clk);
    chk("R10 irq low", {7'd0, irq_n}, 8'h00);
    // R8 writing 1 keeps flag
    wr(A_CTL, 8'h0A);
    repeat (4) @(negedge clk);
    rd(A_CTL, rv); chk("R8 sticky", rv, 8'h0A);
    // R9 clear and match together
    @(negedge clk); reg_addr = A_CTL; reg_wdata = 8'h02; reg_wr = 1'b1; tick_min = 1'b1;
    @(negedge clk); reg_wr = 1'b0; tick_min = 1'b0;
    rd(A_CTL, rv); chk("R9 set wins", rv, 8'h0A);
    // R8 clear
    wr(A_CTL, 8'h02);
    rd(A_CTL, rv); chk("R8 cleared", rv, 8'h02);
    @(negedge clk);
    chk("R8 irq released", {7'd0, irq_n}, 8'h01);
    // R10 timer source
    @(negedge clk); tmr_irq_n = 1'b0;
    @(negedge clk); chk("R10 timer low", {7'd0, irq_n}, 8'h00);
    tmr_irq_n = 1'b1;
    @(negedge clk); chk("R10 timer release", {7'd0, irq_n}, 8'h01);

    finish_run();
  end
endmodule